// File: doc/BRIEF.md
# Quasi-bidirectional I2C port expander

This block is an I2C target with 8 or 16 port pins, chosen by `NUM_PINS`. It has no command byte and no direction register. A write transfer loads an output latch. A read transfer returns the live pin levels. Each pin either drives low (latch bit 0) or is released to a weak pull-up (latch bit 1). A released pin can be pulled low from outside, so it works as an input. Read data is always the sampled pin level; the latch itself cannot be read back.

The serial pair is oversampled by the system clock. SCL, SDA and the pin inputs each pass through a two-flop synchronizer, and the block pulls SDA low through `sda_oe_o`. The 7-bit address has a fixed upper part and takes its low three bits from `addr_sel_i`. Multi-byte transfers carry pins 0..7 first. An active-low interrupt goes low when the pin levels differ from the levels captured at the last read. That read's address acknowledge releases it again.

Top module: `qbx_expander`

## Requirements
- R1: The block acknowledges only the 7-bit address {upper 4 bits, addr_sel_i}. The upper bits are 0x20>>3 by default, or 0x38>>3 when ALT_BASE=1. For any other address it never pulls SDA low, and its state stays unchanged.
- R2: While rst_ni is low, every latch bit is 1, pin_drive_low_o is all zero, int_no is high and sda_oe_o is low.
- R3: pin_drive_low_o[i] is the inverse of latch bit i. The latch is loaded on the acknowledge of one byte (8 pins) or of the second byte of a pair (16 pins). The first byte of a pair is pins 0..7. A single byte on its own leaves a 16-pin latch unchanged.
- R4: In a write longer than one byte (8 pins) or one pair (16 pins), each further complete byte or pair reloads the latch, so the last complete one wins.
- R5: Read data is the synchronized pin levels captured at the read address acknowledge, not the latch. For 16 pins, pins 0..7 come first. Any further bytes repeat the same capture in the same order.
- R6: int_no goes low on the third rising clock edge after a pin input changes so that it differs from the reference capture. A change that does not reach the pin level (the pin is being driven low) leaves int_no high.
- R7: On a read address acknowledge, int_no returns high and the reference capture takes the current synchronized pin levels.
- R8: When the controller NACKs a read byte, the block releases SDA and does not drive it again until the next START.
- R9: The block pulls SDA low to ACK its address and every written byte. sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial pair |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level |
| sda_i | input | 1 | Serial data level as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 3 | Low three address bits |
| pin_i | input | NUM_PINS | Sensed pin levels |
| pin_drive_low_o | output | NUM_PINS | 1 drives the pin low, 0 releases it to the pull-up |
| int_no | output | 1 | Active-low pin-change interrupt |

## Verification
An SCL edge reaches the protocol engine about three clocks late: two synchronizer flops plus the edge register. SDA therefore moves and the latch updates roughly four clocks after the SCL fall that ends a byte. The bench holds each SCL phase for eight to sixteen clocks, reads the ACK and data bits in the middle of the SCL high phase, and checks the pin outputs only after STOP. The interrupt is due on exactly the third rising edge after a pin change. The bench samples it two and three falling edges after driving the change, so both an early and a late interrupt are caught. Read data is compared against the external levels ANDed with the bench's own latch model. The random pass uses a fixed seed.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } qbx_state_e;
endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/qbx_i2c_target.sv
module qbx_i2c_target
  import qbx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] rd_byte_i,
  output logic       sda_oe_o,
  output logic       wr_start_o,
  output logic       wr_byte_vld_o,
  output logic [7:0] wr_byte_o,
  output logic       rd_start_o,
  output logic       rd_next_o
);
  logic [1:0] bus_s;
  logic       scl_s, sda_s, scl_d, sda_d;
  logic       scl_rise, scl_fall, start_det, stop_det;

  qbx_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  qbx_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] rx_q, tx_q;
  logic       rw_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      rx_q          <= '0;
      tx_q          <= '1;
      rw_q          <= 1'b0;
      mack_q        <= 1'b0;
      wr_start_o    <= 1'b0;
      wr_byte_vld_o <= 1'b0;
      rd_start_o    <= 1'b0;
      rd_next_o     <= 1'b0;
    end else begin
      wr_start_o    <= 1'b0;
      wr_byte_vld_o <= 1'b0;
      rd_start_o    <= 1'b0;
      rd_next_o     <= 1'b0;
      if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
      end else if (scl_rise) begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            rx_q  <= {rx_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end
          ST_RD_ACK: mack_q <= ~sda_s;
          default: ;
        endcase
      end else if (scl_fall) begin
        unique case (state_q)
          ST_ADDR: if (cnt_q == 4'd8) begin
            cnt_q <= '0;
            if (rx_q[7:1] == dev_addr_i) begin
              state_q    <= ST_ADDR_ACK;
              rw_q       <= rx_q[0];
              rd_start_o <= rx_q[0];
              wr_start_o <= ~rx_q[0];
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_ADDR_ACK: begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q      <= rd_byte_i;
              rd_next_o <= 1'b1;
              state_q   <= ST_RD;
            end else begin
              state_q <= ST_WR;
            end
          end
          ST_WR: if (cnt_q == 4'd8) begin
            cnt_q         <= '0;
            state_q       <= ST_WR_ACK;
            wr_byte_vld_o <= 1'b1;
          end
          ST_WR_ACK: state_q <= ST_WR;
          ST_RD: begin
            if (cnt_q == 4'd7) begin
              cnt_q   <= '0;
              state_q <= ST_RD_ACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b1};
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_RD_ACK: begin
            if (mack_q) begin
              tx_q      <= rd_byte_i;
              rd_next_o <= 1'b1;
              state_q   <= ST_RD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_byte_o = rx_q;
  assign sda_oe_o  = (state_q == ST_ADDR_ACK) || (state_q == ST_WR_ACK) ||
                     ((state_q == ST_RD) && !tx_q[7]);
endmodule

// File: rtl/qbx_port_regs.sv
module qbx_port_regs #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_s_i,
  input  logic                wr_start_i,
  input  logic                wr_byte_vld_i,
  input  logic [7:0]          wr_byte_i,
  input  logic                rd_start_i,
  input  logic                rd_next_i,
  output logic [7:0]          rd_byte_o,
  output logic [NUM_PINS-1:0] latch_o,
  output logic                int_o
);
  localparam int NUM_BYTES = NUM_PINS / 8;
  localparam int SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_BYTES - 1);

  logic [SEL_W-1:0]    wr_idx_q, rd_idx_q;
  logic [NUM_PINS-1:0] stage_q, stage_nxt, latch_q, cap_q;
  logic                int_q;

  always_comb begin
    stage_nxt = stage_q;
    stage_nxt[{wr_idx_q, 3'b000} +: 8] = wr_byte_i;
  end

  // staging keeps a pair from reaching the pins half-written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q <= '0;
      stage_q  <= '1;
      latch_q  <= '1;
    end else if (wr_start_i) begin
      wr_idx_q <= '0;
    end else if (wr_byte_vld_i) begin
      stage_q  <= stage_nxt;
      wr_idx_q <= (wr_idx_q == LAST) ? '0 : wr_idx_q + 1'b1;
      if (wr_idx_q == LAST) latch_q <= stage_nxt;
    end
  end

  // one capture register serves as read snapshot and interrupt reference
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_q <= '0;
      cap_q    <= '1;
      int_q    <= 1'b0;
    end else begin
      if (rd_start_i) begin
        rd_idx_q <= '0;
        cap_q    <= pins_s_i;
        int_q    <= 1'b0;
      end else begin
        int_q <= (pins_s_i != cap_q);
        if (rd_next_i) rd_idx_q <= (rd_idx_q == LAST) ? '0 : rd_idx_q + 1'b1;
      end
    end
  end

  assign rd_byte_o = cap_q[{rd_idx_q, 3'b000} +: 8];
  assign latch_o   = latch_q;
  assign int_o     = int_q;
endmodule

// File: rtl/qbx_expander.sv
module qbx_expander #(
  parameter int NUM_PINS = 16,
  parameter bit ALT_BASE = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [2:0]          addr_sel_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_drive_low_o,
  output logic                int_no
);
  localparam logic [3:0] ADDR_HI = ALT_BASE ? 4'h7 : 4'h4;

  logic [NUM_PINS-1:0] pins_s, latch;
  logic                wr_start, wr_byte_vld, rd_start, rd_next, int_q;
  logic [7:0]          wr_byte, rd_byte;

  qbx_sync #(.W(NUM_PINS), .RST_VAL({NUM_PINS{1'b1}})) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pins_s)
  );

  qbx_i2c_target u_target (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .dev_addr_i   ({ADDR_HI, addr_sel_i}),
    .rd_byte_i    (rd_byte),
    .sda_oe_o     (sda_oe_o),
    .wr_start_o   (wr_start),
    .wr_byte_vld_o(wr_byte_vld),
    .wr_byte_o    (wr_byte),
    .rd_start_o   (rd_start),
    .rd_next_o    (rd_next)
  );

  qbx_port_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pins_s_i     (pins_s),
    .wr_start_i   (wr_start),
    .wr_byte_vld_i(wr_byte_vld),
    .wr_byte_i    (wr_byte),
    .rd_start_i   (rd_start),
    .rd_next_i    (rd_next),
    .rd_byte_o    (rd_byte),
    .latch_o      (latch),
    .int_o        (int_q)
  );

  assign pin_drive_low_o = ~latch;
  assign int_no          = ~int_q;
endmodule

// File: rtl/qbx_expander_chk.sv
module qbx_expander_chk #(
  parameter int NUM_PINS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                scl_i,
  input logic                sda_oe_o,
  input logic [NUM_PINS-1:0] pin_drive_low_o,
  input logic                int_no,
  input logic                wr_byte_vld,
  input logic                rd_start
);
  p_reset_state_r2: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_drive_low_o == '0) && int_no && !sda_oe_o);

  p_latch_on_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_drive_low_o) |-> $past(wr_byte_vld));

  p_int_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start |=> int_no);

  p_sda_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind qbx_expander qbx_expander_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .scl_i          (scl_i),
  .sda_oe_o       (sda_oe_o),
  .pin_drive_low_o(pin_drive_low_o),
  .int_no         (int_no),
  .wr_byte_vld    (wr_byte_vld),
  .rd_start       (rd_start)
);

// File: tb/qbx_expander_tb_top.sv
module qbx_expander_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] A16 = 7'h25;  // base 0x20, sel 101
  localparam logic [6:0] A8  = 7'h3A;  // base 0x38, sel 010

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe_a, sda_oe_b, sda_bus;
  logic [15:0] ext16, drv16, pin16;
  logic [7:0]  ext8, drv8, pin8;
  logic        int16_n, int8_n;

  assign sda_bus = sda_m & ~sda_oe_a & ~sda_oe_b;
  assign pin16   = ext16 & ~drv16;
  assign pin8    = ext8 & ~drv8;

  qbx_expander #(.NUM_PINS(16), .ALT_BASE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe_a), .addr_sel_i(3'b101), .pin_i(pin16),
    .pin_drive_low_o(drv16), .int_no(int16_n));

  qbx_expander #(.NUM_PINS(8), .ALT_BASE(1'b1)) dut_alt_i (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe_b), .addr_sel_i(3'b010), .pin_i(pin8),
    .pin_drive_low_o(drv8), .int_no(int8_n));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wt(Q);
    scl_m = 1'b1; wt(2 * Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    b = sda_bus; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic nack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(nack);
  endtask

  task automatic rbyte(output logic [7:0] d, input logic last);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(last);
  endtask

  task automatic i2c_wr(input logic [6:0] a, input int n, input logic [31:0] data,
                        output logic [4:0] nacks);
    logic nk;
    nacks = '0;
    i2c_start();
    wbyte({a, 1'b0}, nk);
    nacks[0] = nk;
    for (int k = 0; k < n; k++) begin
      wbyte(data[8*k +: 8], nk);
      nacks[k+1] = nk;
    end
    i2c_stop();
  endtask

  task automatic i2c_rd(input logic [6:0] a, input int n, output logic [31:0] data,
                        output logic nack);
    logic [7:0] d;
    data = '0;
    i2c_start();
    wbyte({a, 1'b1}, nack);
    for (int k = 0; k < n; k++) begin
      rbyte(d, (k == n - 1));
      data[8*k +: 8] = d;
    end
    i2c_stop();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [4:0]  nk;
    logic [31:0] d;
    logic        an, b;
    logic [15:0] lat16;
    logic [7:0]  lat8;
    void'($urandom(32'd2718));
    ext16 = 16'hFFFF;
    ext8  = 8'hFF;
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    wt(5);
    chk("R2 drive_low", {16'h0, drv16}, 32'h0);
    chk("R2 int_n", {31'h0, int16_n}, 32'h1);
    chk("R2 sda_oe", {31'h0, sda_oe_a | sda_oe_b}, 32'h0);
    rst_ni = 1'b1;
    wt(5);
    lat16 = 16'hFFFF;
    lat8  = 8'hFF;

    // R1 foreign addresses
    i2c_wr(7'h24, 2, 32'h0000_00A5, nk);
    chk("R1 nack wrong addr", {31'h0, nk[0]}, 32'h1);
    chk("R1 no latch change", {16'h0, drv16}, 32'h0);
    i2c_wr(7'h3D, 2, 32'h0000_0000, nk);
    chk("R1 alt base not matched", {31'h0, nk[0]}, 32'h1);
    chk("R1 no latch change alt", {16'h0, drv16}, 32'h0);

    // R3 pair write, R9 acks
    i2c_wr(A16, 2, 32'h0000_3C5A, nk);
    lat16 = 16'h3C5A;
    chk("R9 acks", {27'h0, nk[2:0]}, 32'h0);
    chk("R3 pair", {16'h0, drv16}, {16'h0, ~lat16});
    i2c_wr(A16, 1, 32'h0000_0000, nk);
    chk("R3 lone byte ignored", {16'h0, drv16}, {16'h0, ~lat16});

    // R4 extra pair reloads latch
    i2c_wr(A16, 4, 32'h1234_ABCD, nk);
    lat16 = 16'h1234;
    chk("R9 acks 4 bytes", {27'h0, nk}, 32'h0);
    chk("R4 last pair wins", {16'h0, drv16}, {16'h0, ~lat16});

    // R5 read repeats snapshot
    ext16 = 16'hF0F0;
    wt(10);
    i2c_rd(A16, 4, d, an);
    chk("R5 addr ack", {31'h0, an}, 32'h0);
    chk("R5 low pair", {16'h0, d[15:0]}, {16'h0, ext16 & lat16});
    chk("R5 repeated pair", {16'h0, d[31:16]}, {16'h0, ext16 & lat16});

    // R8 NACK releases SDA
    i2c_start();
    wbyte({A16, 1'b1}, an);
    rbyte(d[7:0], 1'b1);
    chk("R8 released after nack", {31'h0, sda_oe_a}, 32'h0);
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[8+i] = b;
    end
    chk("R8 no drive until start", {24'h0, d[15:8]}, 32'hFF);
    i2c_stop();
    wt(5);

    // R6 / R7 interrupt
    chk("R7 int high after read", {31'h0, int16_n}, 32'h1);
    ext16 = ext16 ^ 16'h0001;  // pin 0 driven low: no level change
    wt(8);
    chk("R6 masked change", {31'h0, int16_n}, 32'h1);
    ext16 = ext16 ^ 16'h0010;  // pin 4 released (latch bit 1), falls
    wt(2);
    chk("R6 not early", {31'h0, int16_n}, 32'h1);
    wt(1);
    chk("R6 asserted", {31'h0, int16_n}, 32'h0);
    i2c_rd(A16, 2, d, an);
    chk("R5 read after change", {16'h0, d[15:0]}, {16'h0, ext16 & lat16});
    chk("R7 cleared by read", {31'h0, int16_n}, 32'h1);

    // R1 / R3 / R5 on 8-pin alternate-base instance
    i2c_wr(A8, 1, 32'h0000_0096, nk);
    lat8 = 8'h96;
    chk("R1 alt ack", {30'h0, nk[1:0]}, 32'h0);
    chk("R3 8-pin byte", {24'h0, drv8}, {24'h0, ~lat8});
    chk("R1 other device untouched", {16'h0, drv16}, {16'h0, ~lat16});
    ext8 = 8'h5F;
    wt(6);
    i2c_rd(A8, 2, d, an);
    chk("R5 8-pin read", {16'h0, d[15:0]}, {16'h0, {2{ext8 & lat8}}});

    for (int it = 0; it < 30; it++) begin
      logic [31:0] w;
      w = $urandom;
      i2c_wr(A16, 2, w, nk);
      lat16 = w[15:0];
      chk("R3 random pair", {16'h0, drv16}, {16'h0, ~lat16});
      ext16 = 16'($urandom);
      wt(4);
      i2c_rd(A16, 2, d, an);
      chk("R5 random read", {16'h0, d[15:0]}, {16'h0, ext16 & lat16});
      chk("R7 random clear", {31'h0, int16_n}, 32'h1);
    end
    for (int it = 0; it < 10; it++) begin
      logic [31:0] w;
      w = $urandom;
      i2c_wr(A8, 2, w, nk);
      lat8 = w[15:8];
      chk("R4 8-pin second byte", {24'h0, drv8}, {24'h0, ~lat8});
      ext8 = 8'($urandom);
      wt(4);
      i2c_rd(A8, 1, d, an);
      chk("R5 8-pin random read", {24'h0, d[7:0]}, {24'h0, ext8 & lat8});
    end
    summary();
  end
endmodule